// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a clocked model of the command decoder in a byte-wide NOR-style flash device. The host drives single-cycle write strobes that carry a 19-bit address and a data byte, and single-cycle read strobes that carry an address. The data byte of a write is decoded as a command. Erasing or programming always takes two writes. The first write is a setup byte. The second write is either the erase confirm byte or the program address and data. Once an operation starts, it runs for a number of clock cycles set by a parameter. During that time reads return a status byte instead of array data.

A small on-chip RAM stands in for the cells. It holds `2**MEM_AW` bytes and is indexed by the low `MEM_AW` address bits, so higher bits alias. An erase fills one 256-byte sector with FFh, sweeping one byte per cycle from the start of the busy period. A program ANDs the new byte into the old contents when its timer ends. A separate block supplies the protection input. While it is high, the controller refuses to start erase or program, but reset and identification still work. The reset command FFh cancels a pending setup. It also aborts a running operation, and an aborted erase can leave the sector partly erased.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read mode, `busy_o` is low and `rd_valid` is low.
- R2: Writing 20h and then D0h starts a sector erase. The sector is selected by address bits 18:8, and bits 7:0 of the confirm write are ignored. `busy_o` is high for exactly ERASE_CYCLES cycles, after which every byte of that sector reads FFh and other sectors are unchanged.
- R3: Writing 10h and then any byte other than FFh programs that byte at the address of the second write. `busy_o` is high for exactly PROG_CYCLES cycles, after which the location holds old AND new.
- R4: Writing 90h enters identification mode. There a read of address 0 returns BFh, a read of address 1 returns 04h and any other address returns 00h. Writing 20h, 10h or FFh leaves the mode.
- R5: FFh written in erase setup or program setup returns to read mode with no change to the array.
- R6: In erase setup, a write of any byte other than D0h returns to read mode without starting an erase.
- R7: While `protect_i` is high, 20h and 10h are ignored and no operation starts. 90h and FFh still take effect.
- R8: While busy, writes other than FFh are ignored. FFh drops `busy_o` on the next cycle. A program aborted this way leaves its byte unchanged. An aborted erase leaves the start of the sector erased and its end unchanged.
- R9: A read strobe in cycle t gives `rd_data` with `rd_valid` high in cycle t+1 only.
- R10: A read while busy returns a status byte. Bit 6 inverts on each successive status read, starting at 0 after reset. Bit 7 is the complement of bit 7 of the byte being programmed, and 0 during an erase. Bits 5:0 are 0.
- R11: In read mode a write whose byte is not one of 20h, 10h, 90h or FFh has no effect. D0h is among the bytes ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Host read strobe, one cycle |
| rd_addr | input | 19 | Read address |
| protect_i | input | 1 | Protection active, blocks erase and program |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| busy_o | output | 1 | Erase or program in progress |

## Verification
A command write sampled at edge E changes the mode at E. An execute write raises `busy_o` in the cycle right after E and holds it for ERASE_CYCLES or PROG_CYCLES cycles. The bench counts those cycles at falling edges and compares the count with the parameter. An abort drops `busy_o` one cycle after the FFh write, and the bench checks this at the next falling edge. Read results are due one cycle after the strobe. The driver queues each expected byte when it issues the strobe, and the monitor compares it at the falling edge where `rd_valid` is high. The programmed value appears at the edge that ends busy, so array reads are issued only after `busy_o` has fallen.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ       = 3'd0,
    M_SET_ERASE  = 3'd1,
    M_SET_PROG   = 3'd2,
    M_ID         = 3'd3,
    M_BUSY_ERASE = 3'd4,
    M_BUSY_PROG  = 3'd5
  } mode_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h10;
  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam logic [7:0] CMD_ID          = 8'h90;

  function automatic logic is_busy(mode_e m);
    return (m == M_BUSY_ERASE) || (m == M_BUSY_PROG);
  endfunction

  // bits can only fall from 1 to 0
  function automatic logic [7:0] merge_prog(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(logic prog, logic [7:0] pdata, logic tog);
    return {(prog ? ~pdata[7] : 1'b0), tog, 6'b0};
  endfunction

  function automatic logic [7:0] id_byte(logic [18:0] a, logic [7:0] mfr, logic [7:0] dev);
    if (a == 19'd0) return mfr;
    if (a == 19'd1) return dev;
    return 8'h00;
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              protect_i,
  input  logic              op_done,
  output mode_e             mode_q,
  output logic              start_erase,
  output logic              start_prog,
  output logic              abort_op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  mode_e mode_d;

  always_comb begin
    mode_d      = mode_q;
    start_erase = 1'b0;
    start_prog  = 1'b0;
    abort_op    = 1'b0;
    case (mode_q)
      M_READ, M_ID: begin
        if (wr_en) begin
          if (wr_data == CMD_ERASE_SETUP && !protect_i)     mode_d = M_SET_ERASE;
          else if (wr_data == CMD_PROG_SETUP && !protect_i) mode_d = M_SET_PROG;
          else if (wr_data == CMD_ID)                       mode_d = M_ID;
          else if (wr_data == CMD_RESET)                    mode_d = M_READ;
        end
      end
      M_SET_ERASE: begin
        if (wr_en) begin
          if (wr_data == CMD_ERASE_GO && !protect_i) begin
            start_erase = 1'b1;
            mode_d      = M_BUSY_ERASE;
          end else begin
            mode_d = M_READ;
          end
        end
      end
      M_SET_PROG: begin
        if (wr_en) begin
          if (wr_data == CMD_RESET || protect_i) begin
            mode_d = M_READ;
          end else begin
            start_prog = 1'b1;
            mode_d     = M_BUSY_PROG;
          end
        end
      end
      M_BUSY_ERASE, M_BUSY_PROG: begin
        if (wr_en && wr_data == CMD_RESET) begin
          abort_op = 1'b1;
          mode_d   = M_READ;
        end else if (op_done) begin
          mode_d = M_READ;
        end
      end
      default: mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_READ;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      mode_q <= mode_d;
      if (start_erase || start_prog) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W      = 20,
  parameter int SECT_BYTES = 256,
  localparam int IDX_W     = $clog2(SECT_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             abort,
  output logic             running,
  output logic             done,
  output logic             sweep_active,
  output logic [IDX_W-1:0] sweep_idx
);

  logic [CNT_W-1:0] cnt_q;

  assign done         = running && (cnt_q == '0);
  assign sweep_active = running && (sweep_idx < IDX_W'(SECT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt_q     <= '0;
      sweep_idx <= '0;
    end else if (start) begin
      running   <= 1'b1;
      cnt_q     <= len - CNT_W'(1);
      sweep_idx <= '0;
    end else if (running) begin
      if (abort || cnt_q == '0) running <= 1'b0;
      else                      cnt_q   <= cnt_q - CNT_W'(1);
      if (sweep_active) sweep_idx <= sweep_idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int MEM_AW = 10,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MEM_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [MEM_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 19,
  parameter int          DATA_W       = 8,
  parameter int          MEM_AW       = 10,
  parameter int          SECT_AW      = 8,
  parameter int          ERASE_CYCLES = 500000,
  parameter int          PROG_CYCLES  = 4375,
  parameter logic [7:0]  MFR_ID       = 8'hBF,
  parameter logic [7:0]  DEV_ID       = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              protect_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy_o
);

  localparam int SECT_BYTES = 1 << SECT_AW;
  localparam int MAX_CYC    = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYC + 1) + 1;
  localparam int IDX_W      = SECT_AW + 1;

  // named internal events, observed by the checker
  mode_e             mode_q;
  logic              start_erase, start_prog, abort_op, op_done;
  logic              mem_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic              running, sweep_active;
  logic [IDX_W-1:0]  sweep_idx;
  logic [MEM_AW-1:0] waddr;
  logic [DATA_W-1:0] wdata, rdata_a, rdata_b;
  logic              erase_we, prog_we;
  logic              toggle_q;
  logic              unused_bits;

  flash_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .protect_i(protect_i), .op_done(op_done), .mode_q(mode_q),
    .start_erase(start_erase), .start_prog(start_prog), .abort_op(abort_op),
    .op_addr(op_addr), .op_data(op_data)
  );

  flash_op_timer #(.CNT_W(CNT_W), .SECT_BYTES(SECT_BYTES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_erase || start_prog),
    .len(start_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES)),
    .abort(abort_op), .running(running), .done(op_done),
    .sweep_active(sweep_active), .sweep_idx(sweep_idx)
  );

  assign erase_we = (mode_q == M_BUSY_ERASE) && sweep_active && !abort_op;
  assign prog_we  = (mode_q == M_BUSY_PROG) && op_done && !abort_op;
  assign mem_we   = erase_we || prog_we;
  assign waddr    = erase_we ? {op_addr[MEM_AW-1:SECT_AW], sweep_idx[SECT_AW-1:0]}
                             : op_addr[MEM_AW-1:0];
  assign wdata    = erase_we ? '1 : merge_prog(rdata_b, op_data);
  assign busy_o   = running;
  assign unused_bits = ^{op_addr[ADDR_W-1:MEM_AW], sweep_idx[SECT_AW]};

  flash_cell_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .raddr_a(rd_addr[MEM_AW-1:0]), .rdata_a(rdata_a),
    .raddr_b(op_addr[MEM_AW-1:0]), .rdata_b(rdata_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      toggle_q <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (running) begin
          rd_data  <= status_byte(mode_q == M_BUSY_PROG, op_data, toggle_q);
          toggle_q <= ~toggle_q;
        end else if (mode_q == M_ID) begin
          rd_data <= id_byte(rd_addr, MFR_ID, DEV_ID);
        end else begin
          rd_data <= rdata_a;
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       busy_o,
  input logic       protect_i,
  input mode_e      mode_q,
  input logic       start_erase,
  input logic       start_prog,
  input logic       abort_op,
  input logic       mem_we
);

  assert_busy_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == is_busy(mode_q));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_erase || start_prog) |=> busy_o);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_op |=> !busy_o);

  assert_protect_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_erase || start_prog) |-> !protect_i);

  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_we_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_o);

  assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SET_ERASE && wr_en && wr_data == 8'hFF) |=> (mode_q == M_READ));

  assert_bad_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SET_ERASE && wr_en && wr_data != 8'hD0) |=> !busy_o);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_valid(rd_valid), .busy_o(busy_o), .protect_i(protect_i), .mode_q(mode_q),
  .start_erase(start_erase), .start_prog(start_prog), .abort_op(abort_op),
  .mem_we(mem_we)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

  localparam int ERASE_N = 300;
  localparam int PROG_N  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, protect_i = 1'b0;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, busy_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] model [1024];
  logic       tog = 1'b0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ERASE_CYCLES(ERASE_N), .PROG_CYCLES(PROG_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .protect_i(protect_i),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy_o(busy_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [18:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_status(bit prog, logic [7:0] pd, string tag);
    rd(19'd0, {(prog ? ~pd[7] : 1'b0), tog, 6'b0}, tag);
    tog = ~tog;
  endtask

  task automatic wait_busy(int exp_len, string tag);
    int n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    check(n == exp_len, tag, n, exp_len);
  endtask

  // monitor: compares read results in the cycle they are due
  always @(negedge clk) begin
    if (rd_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R9 unexpected rd_valid", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && rd_valid == 1'b0, "R1 idle after release", busy_o, 0);

    // R2: erase each sector, low address bits nonzero, count busy cycles
    for (int s = 0; s < 4; s++) begin
      wr(19'h0, 8'h20);
      wr(19'((s << 8) | 8'h37), 8'hD0);
      check(busy_o == 1'b1, "R2 busy after erase", busy_o, 1);
      if (s == 0) rd_status(1'b0, 8'h00, "R10 erase status");
      wait_busy((s == 0) ? ERASE_N - 2 : ERASE_N, "R2 erase busy length");
      for (int i = 0; i < 256; i++) model[s*256 + i] = 8'hFF;
    end
    rd(19'h000, 8'hFF, "R2 sector0 first");
    rd(19'h0FF, 8'hFF, "R2 sector0 last");
    rd(19'h3FF, 8'hFF, "R2 sector3 last");

    // R3: program and AND-merge
    wr(19'h0, 8'h10); wr(19'h005, 8'hA5);
    wait_busy(PROG_N, "R3 program busy length");
    rd(19'h005, 8'hA5, "R3 program byte");
    wr(19'h0, 8'h10); wr(19'h005, 8'h0F);
    wait_busy(PROG_N, "R3 second program length");
    rd(19'h005, 8'h05, "R3 AND merge");
    model[5] = 8'h05;

    // R10: status while programming
    wr(19'h0, 8'h10); wr(19'h010, 8'h3C);
    rd_status(1'b1, 8'h3C, "R10 status first");
    rd_status(1'b1, 8'h3C, "R10 status second");
    while (busy_o) @(negedge clk);
    rd(19'h010, 8'h3C, "R10 data after completion");
    model[16] = 8'h3C;

    // R8: aborted erase of sector 1
    wr(19'h0, 8'h10); wr(19'h100, 8'h00); while (busy_o) @(negedge clk);
    wr(19'h0, 8'h10); wr(19'h1FF, 8'h00); while (busy_o) @(negedge clk);
    wr(19'h0, 8'h20); wr(19'h100, 8'hD0);
    repeat (20) @(negedge clk);
    wr(19'h1FF, 8'h10);
    check(busy_o == 1'b1, "R8 write ignored while busy", busy_o, 1);
    wr(19'h0, 8'hFF);
    check(busy_o == 1'b0, "R8 abort drops busy", busy_o, 0);
    rd(19'h100, 8'hFF, "R8 swept byte erased");
    rd(19'h1FF, 8'h00, "R8 unswept byte kept");
    // R8: aborted program
    wr(19'h0, 8'h10); wr(19'h020, 8'h00);
    wr(19'h0, 8'hFF);
    check(busy_o == 1'b0, "R8 program abort", busy_o, 0);
    rd(19'h020, 8'hFF, "R8 aborted program unchanged");

    // R5 / R11 / R6
    wr(19'h0, 8'h10); wr(19'h200, 8'h12); while (busy_o) @(negedge clk);
    wr(19'h0, 8'h20); wr(19'h200, 8'hFF);
    check(busy_o == 1'b0, "R5 erase cancel", busy_o, 0);
    wr(19'h200, 8'hD0);
    check(busy_o == 1'b0, "R11 D0 ignored in read mode", busy_o, 0);
    wr(19'h0, 8'h10); wr(19'h201, 8'hFF);
    check(busy_o == 1'b0, "R5 program cancel", busy_o, 0);
    wr(19'h200, 8'h55);
    check(busy_o == 1'b0, "R11 unknown byte ignored", busy_o, 0);
    rd(19'h200, 8'h12, "R5 array unchanged");
    rd(19'h201, 8'hFF, "R5 cancelled program");
    wr(19'h0, 8'h20); wr(19'h200, 8'h55);
    check(busy_o == 1'b0, "R6 bad confirm", busy_o, 0);
    wr(19'h200, 8'hD0);
    check(busy_o == 1'b0, "R6 back in read mode", busy_o, 0);
    rd(19'h200, 8'h12, "R6 array unchanged");

    // R4: identification
    wr(19'h0, 8'h90);
    rd(19'h0, 8'hBF, "R4 maker byte");
    rd(19'h1, 8'h04, "R4 device byte");
    rd(19'h2, 8'h00, "R4 other address");
    wr(19'h0, 8'hFF);
    rd(19'h0, model[0], "R4 left by FF");
    wr(19'h0, 8'h90); wr(19'h0, 8'h10); wr(19'h040, 8'h77);
    check(busy_o == 1'b1, "R4 program from ID mode", busy_o, 1);
    while (busy_o) @(negedge clk);
    rd(19'h040, 8'h77, "R4 program after ID");

    // R7: protection
    protect_i = 1'b1;
    wr(19'h0, 8'h20); wr(19'h200, 8'hD0);
    check(busy_o == 1'b0, "R7 erase refused", busy_o, 0);
    wr(19'h0, 8'h10); wr(19'h202, 8'h00);
    check(busy_o == 1'b0, "R7 program refused", busy_o, 0);
    rd(19'h200, 8'h12, "R7 array kept");
    rd(19'h202, 8'hFF, "R7 byte kept");
    wr(19'h0, 8'h90);
    rd(19'h0, 8'hBF, "R7 ID accepted");
    wr(19'h0, 8'hFF);
    rd(19'h1, 8'hFF, "R7 reset accepted");
    protect_i = 1'b0;

    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R9 no valid without strobe", rd_valid, 0);
    check(q_exp.size() == 0, "R9 all reads returned", q_exp.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule